// File: doc/BRIEF.md
# Half-Cycle Read Latency Aligner

This block turns a one-cycle read-issue strobe into the data-valid window of a double-data-rate read. When a read is accepted, the block stores the latency setting and the burst length that are present on that clock edge. It delays the event by two full clocks. When half-cycle latency is selected, it adds another half clock on the falling edge. It then holds a valid flag for as many clocks as the burst needs. Each clock carries two beats, so the window lasts half the burst length in clocks.

A phase output marks windows that start on a falling edge. Downstream capture logic can use it to pick which clock edge to sample. Reads that arrive while a window is still open take over that window. When reads are spaced exactly one burst apart, the valid windows join into one unbroken stretch.

Top module: `rd_latency_aligner`

## Requirements
- R1: While `rst_n` is low, `rd_valid` and `rd_phase` are both 0.
- R2: A read accepted at rising edge n with `cl_half`=0 raises `rd_valid` right after rising edge n+2, and `rd_phase` stays 0 for that window.
- R3: A read accepted at rising edge n with `cl_half`=1 raises `rd_valid` right after the falling edge that follows rising edge n+2, and `rd_phase` is 1 for the whole window.
- R4: The window length is set by `bl_code`: 2'b01 gives a 2-beat burst and 1 clock, 2'b10 gives 4 beats and 2 clocks, 2'b11 gives 8 beats and 4 clocks.
- R5: A read strobe with `bl_code`=2'b00 (reserved) is dropped. It opens no window and does not change a window already in flight.
- R6: Reads of the same latency, spaced exactly burst-length/2 clocks apart, produce one continuous `rd_valid` window with no idle half-cycle.
- R7: A read whose window starts before the previous window ends cuts the previous window at that point. `rd_valid` then stays high to the end of the new burst.
- R8: Latency and burst length are captured with the strobe. Changing `cl_half` or `bl_code` later has no effect on a read already accepted.
- R9: `rd_phase` is 0 whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | One-cycle read-issue strobe, sampled on the rising edge |
| cl_half | input | 1 | Latency select: 0 for 2 clocks, 1 for 2.5 clocks |
| bl_code | input | 2 | Burst length code (01 = 2, 10 = 4, 11 = 8, 00 = reserved) |
| rd_valid | output | 1 | Read data valid window |
| rd_phase | output | 1 | 1 while a falling-edge-aligned window is active |

## Verification
The bench samples the outputs every half clock, so the checks can see a half-cycle shift.

- **Wrong edge.** A design that used the wrong edge for 2.5-clock reads would be off by one half-slot at both ends of the window.
- **Gaps between reads.** Back-to-back reads at the burst spacing, at both latencies, expose a design that drops valid for one cycle between bursts.
- **Truncation.** A long burst cut short by a quick follow-up read exposes a design that lets the first window run on.
- **Reserved code.** A reserved-code strobe sent in the middle of a live burst catches a design that truncates the window or opens a zero-length one.
- **Late setting changes.** Changing the settings just after a strobe catches a design that reads them late instead of latching them with the command.

// File: rtl/rdalign_pkg.sv
package rdalign_pkg;

  localparam int MAX_BURST     = 8;
  localparam int BEATS_PER_CLK = 2;
  localparam int MAX_CLK       = MAX_BURST / BEATS_PER_CLK;
  localparam int CLK_W         = $clog2(MAX_CLK + 1);

  typedef enum logic [1:0] {
    BL_RSVD = 2'b00,
    BL_2    = 2'b01,
    BL_4    = 2'b10,
    BL_8    = 2'b11
  } burst_code_e;

  typedef struct packed {
    logic             go;
    logic             half;
    logic [CLK_W-1:0] nclk;
  } rd_req_t;

  // Clocks a burst occupies: beats are 2^code, two beats per clock.
  function automatic logic [CLK_W-1:0] burst_clocks(input logic [1:0] code);
    int beats;
    if (code == BL_RSVD) return '0;
    beats = 1 << int'(code);
    return CLK_W'(beats / BEATS_PER_CLK);
  endfunction

endpackage

// File: rtl/rd_cmd_delay.sv
module rd_cmd_delay
  import rdalign_pkg::*;
#(
  parameter int LAT_INT = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  rd_req_t req_in,
  output rd_req_t req_out,
  output logic    first_go
);

  rd_req_t stage [LAT_INT];

  for (genvar i = 0; i < LAT_INT; i++) begin : g_stage
    rd_req_t nxt;
    if (i == 0) begin : g_head
      assign nxt = req_in;
    end else begin : g_tail
      assign nxt = stage[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= nxt;
    end
  end

  assign req_out  = stage[LAT_INT-1];
  assign first_go = stage[0].go;

endmodule

// File: rtl/rd_window_count.sv
module rd_window_count
  import rdalign_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  rd_req_t launch,
  output logic    win_pos,
  output logic    win_half
);

  logic [CLK_W-1:0] cnt;
  logic             load_evt;

  assign load_evt = launch.go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      win_half <= 1'b0;
    end else if (load_evt) begin
      cnt      <= launch.nclk;
      win_half <= launch.half;
    end else if (cnt != '0) begin
      cnt      <= cnt - 1'b1;
    end
  end

  assign win_pos = (cnt != '0);

  assert_idle_stays_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !win_pos) |=> !win_pos);

  assert_window_runs_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_pos && !load_evt && cnt > 1) |=> win_pos);

  assert_reload_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_pos && load_evt) |=> win_pos);

endmodule

// File: rtl/rd_half_shift.sv
module rd_half_shift (
  input  logic clk,
  input  logic rst_n,
  input  logic win_pos,
  input  logic win_half,
  output logic rd_valid,
  output logic rd_phase
);

  logic neg_valid;
  logic neg_half;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_valid <= 1'b0;
      neg_half  <= 1'b0;
    end else begin
      neg_valid <= win_pos;
      neg_half  <= win_half;
    end
  end

  assign rd_valid = (win_pos && !win_half) || (neg_valid && neg_half);
  assign rd_phase = neg_valid && neg_half;

  assert_phase_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> rd_valid);

  assert_full_cycle_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_pos && !win_half) |-> (rd_valid && !rd_phase));

  assert_half_follows_neg_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (win_pos && win_half) |=> (rd_valid && rd_phase));

endmodule

// File: rtl/rd_latency_aligner.sv
module rd_latency_aligner
  import rdalign_pkg::*;
#(
  parameter int LAT_INT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_cmd,
  input  logic       cl_half,
  input  logic [1:0] bl_code,
  output logic       rd_valid,
  output logic       rd_phase
);

  rd_req_t req_in;
  rd_req_t launch;
  logic    first_go;
  logic    win_pos;
  logic    win_half;

  assign req_in.go   = rd_cmd && (bl_code != BL_RSVD);
  assign req_in.half = cl_half;
  assign req_in.nclk = burst_clocks(bl_code);

  rd_cmd_delay #(.LAT_INT(LAT_INT)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (req_in),
    .req_out  (launch),
    .first_go (first_go)
  );

  rd_window_count u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .win_pos  (win_pos),
    .win_half (win_half)
  );

  rd_half_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_pos  (win_pos),
    .win_half (win_half),
    .rd_valid (rd_valid),
    .rd_phase (rd_phase)
  );

  assert_reserved_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && bl_code == BL_RSVD) |=> !first_go);

  assert_strobe_enters_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && bl_code != BL_RSVD) |=> first_go);

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!rd_valid && !rd_phase);
  end

endmodule

// File: tb/rd_latency_aligner_bench.sv
`timescale 1ns/1ps
module rd_latency_aligner_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_cmd = 1'b0;
  logic       cl_half = 1'b0;
  logic [1:0] bl_code = 2'b01;
  logic       rd_valid;
  logic       rd_phase;

  int checks = 0;
  int failures = 0;
  int pe = 0;
  bit mon_en = 0;
  bit done = 0;
  string idle_tag = "R9";

  typedef struct {
    int    start;
    int    stop;
    bit    ph;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) pe <= pe + 1;

  rd_latency_aligner u_rd_latency_aligner (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .cl_half(cl_half),
    .bl_code(bl_code), .rd_valid(rd_valid), .rd_phase(rd_phase)
  );

  function automatic int clocks_of(input logic [1:0] c);
    case (c)
      2'b01:   return 1;
      2'b10:   return 2;
      2'b11:   return 4;
      default: return 0;
    endcase
  endfunction

  task automatic check_bits(input string tag, input int slot,
                            input logic av, input logic ev,
                            input logic ap, input logic ep);
    checks++;
    if (av !== ev || ap !== ep) begin
      failures++;
      $display("FAIL %s slot %0d: rd_valid=%0b exp %0b rd_phase=%0b exp %0b",
               tag, slot, av, ev, ap, ep);
    end
  endtask

  task automatic slot_check(input int h);
    logic  ev = 1'b0;
    logic  ep = 1'b0;
    string tg = idle_tag;
    while (sb.size() > 0 && sb[0].stop <= h) void'(sb.pop_front());
    if (sb.size() > 0 && sb[0].start <= h) begin
      ev = 1'b1;
      ep = sb[0].ph;
      tg = sb[0].tag;
    end
    check_bits(tg, h, rd_valid, ev, rd_phase, ep);
  endtask

  // Driver: strobe for one cycle; the read registers at the next rising edge.
  task automatic issue(input bit half, input logic [1:0] bl, input string tag);
    int   n;
    exp_t e;
    @(negedge clk);
    rd_cmd  = 1'b1;
    cl_half = half;
    bl_code = bl;
    n = pe + 1;
    if (bl != 2'b00) begin
      e.start = 2 * (n + 2) + int'(half);
      e.stop  = e.start + 2 * clocks_of(bl);
      e.ph    = half;
      e.tag   = tag;
      if (sb.size() > 0 && sb[$].stop > e.start) sb[$].stop = e.start;
      sb.push_back(e);
    end
  endtask

  task automatic gap(input int k);
    @(negedge clk);
    rd_cmd = 1'b0;
    repeat (k - 1) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (mon_en) slot_check(2 * pe);
      @(negedge clk); #2;
      if (mon_en) slot_check(2 * pe + 1);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check_bits("R1", -1, rd_valid, 1'b0, rd_phase, 1'b0);
    @(posedge clk); #2;
    check_bits("R1", -1, rd_valid, 1'b0, rd_phase, 1'b0);
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R3: both latencies, 4-beat burst
    issue(0, 2'b10, "R2"); gap(8);
    issue(1, 2'b10, "R3"); gap(8);

    // R4: every burst length at both latencies
    issue(0, 2'b01, "R4"); gap(6);
    issue(0, 2'b11, "R4"); gap(8);
    issue(1, 2'b11, "R4"); gap(8);
    issue(1, 2'b01, "R4"); gap(6);

    // R5: reserved code alone and in the middle of a live burst
    idle_tag = "R5";
    issue(0, 2'b00, "R5"); gap(6);
    issue(0, 2'b11, "R5"); gap(1);
    issue(0, 2'b00, "R5"); gap(8);
    idle_tag = "R9";

    // R6: back-to-back at burst spacing
    issue(0, 2'b10, "R6"); gap(1);
    issue(0, 2'b10, "R6"); gap(1);
    issue(0, 2'b10, "R6"); gap(8);
    issue(1, 2'b01, "R6");
    issue(1, 2'b01, "R6");
    issue(1, 2'b01, "R6"); gap(8);
    issue(1, 2'b11, "R6"); gap(3);
    issue(1, 2'b11, "R6"); gap(8);

    // R7: early follow-up truncates a long burst
    issue(0, 2'b11, "R7");
    issue(0, 2'b01, "R7"); gap(8);
    issue(1, 2'b11, "R7"); gap(1);
    issue(1, 2'b10, "R7"); gap(8);

    // R8: settings change right after the strobe
    issue(1, 2'b11, "R8");
    @(negedge clk);
    rd_cmd  = 1'b0;
    cl_half = 1'b0;
    bl_code = 2'b01;
    repeat (8) @(negedge clk);
    issue(0, 2'b01, "R8");
    @(negedge clk);
    rd_cmd  = 1'b0;
    cl_half = 1'b1;
    bl_code = 2'b11;
    repeat (8) @(negedge clk);

    mon_en = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run state=hung exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule